// File: doc/BRIEF.md
# Instruction Fetch Address Translation Stage

This stage converts the virtual address of an instruction fetch into a physical address, or reports why it cannot. It gives a result in the same cycle as the request. Before the page table lookup, it tries three bypass routes in a fixed order:
- a privileged-code marker in the fetch address (bit 0 set);
- a request that is flagged as already physical;
- a direct-mapped kernel window selected by the top two implemented virtual address bits.

Only if none of these applies does it use the external translation buffer. The stage drives the virtual page number and address space number into that buffer. The buffer returns a hit flag, a page frame number and a per-mode read/execute enable mask.

Any physical address with bits above the implemented width becomes a machine-check fault. Addresses in the uncached region are marked as such.

Two registers record miss and access-violation faults. The first captures the faulting virtual address. The second captures a pre-formatted pointer into the virtual page table: the table base, plus the virtual page number scaled to an 8-byte entry. Fault handlers read these pointers directly. Filling the translation buffer is handled outside this block.

Top module: `itx_fetch_xlate`

## Requirements
- R1: When `vaddr_i[0]` is 1 (privileged-code marker), `paddr_o` is `vaddr_i` masked to bits 43:0 with bits 1:0 cleared, and `fault_o` is none (0). This path wins over every other path, including `phys_i`.
- R2: When bit 0 is clear and `phys_i` is 1, `paddr_o` equals `vaddr_i`. This path wins over the kernel window.
- R3: The kernel window applies when neither of the above holds, `sp_ctl_i[1]` is 1 and `vaddr_i[42:41]` is 2. In kernel mode (`mode_i`=0), the address is `vaddr_i[43:0]`. If bit 39 or bit 40 of that value is set, bits 43:40 are forced to ones; otherwise the address is truncated to bits 39:0.
- R4: A kernel window access with `mode_i` other than 0 gives `fault_o` = access violation (1).
- R5: On the translated path, `tlb_hit_i`=0 gives `fault_o` = miss (2).
- R6: On a translated hit, `paddr_o` = {`tlb_pfn_i`, `vaddr_i[12:2]`, 2'b00}. If `tlb_xre_i[mode_i]` is 0, the result is an access violation (1) instead.
- R7: A fault-free result with any bit set above bit 43 becomes a machine check (3).
- R8: `uncached_o` is 1 exactly when the result is fault-free and `paddr_o` has bit 39 or bit 40 set. Whenever `fault_o` is non-zero, `paddr_o` is 0.
- R9: When a valid request with `upd_en_i`=1 ends in a miss or an access violation, the next clock edge loads `fault_tag_o` with `vaddr_i` and `va_form_o` with `ptbase_i | (vaddr_i[42:13] << 3)`.
- R10: The fault registers reset to 0 and keep their value in every other case: no request, `upd_en_i` low, no fault, or a machine check. With `req_valid_i` low, `fault_o`, `paddr_o` and `uncached_o` are 0.
- R11: `tlb_vpn_o` is `vaddr_i[42:13]` and `tlb_asn_o` is `asn_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fetch request valid |
| vaddr_i | input | 64 | Fetch virtual address |
| phys_i | input | 1 | Request already carries a physical address |
| upd_en_i | input | 1 | Allow fault registers to be written |
| mode_i | input | 2 | Current mode, 0 = kernel |
| sp_ctl_i | input | 2 | Kernel window control, bit 1 enables |
| asn_i | input | 8 | Current address space number |
| ptbase_i | input | 64 | Virtual page table base |
| tlb_vpn_o | output | 30 | Virtual page number for the lookup |
| tlb_asn_o | output | 8 | Address space number for the lookup |
| tlb_hit_i | input | 1 | Lookup hit |
| tlb_pfn_i | input | 32 | Page frame number from the lookup |
| tlb_xre_i | input | 4 | Read/execute enable, one bit per mode |
| paddr_o | output | 64 | Physical address, 0 on fault |
| fault_o | output | 2 | 0 none, 1 access violation, 2 miss, 3 machine check |
| uncached_o | output | 1 | Result lies in the uncached region |
| fault_tag_o | output | 64 | Last faulting virtual address |
| va_form_o | output | 64 | Last formatted page table pointer |

## Verification
Two functions can act in the same cycle. A fault register update from one request happens at the same clock edge that presents the next request's translation. The bench provokes this with back-to-back faulting requests, varying `upd_en_i` between them. It judges the combinational outputs of the current request separately from the registers left by the previous one.

A second overlap is between the uncached marking and the machine check. Physical-flag requests and high frame numbers put bits 39/40 and bits above 43 into one address, and `uncached_o` must then stay low. A behavioural reference model is compared against the outputs on every cycle of directed and random traffic.

// File: rtl/itx_pkg.sv
package itx_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ACV  = 2'd1,
    FLT_MISS = 2'd2,
    FLT_MCHK = 2'd3
  } itx_fault_e;
endpackage

// File: rtl/itx_bypass.sv
module itx_bypass #(
  parameter int VA_W       = 64,
  parameter int PA_IMPL_W  = 44,
  parameter int VA_IMPL_W  = 43,
  parameter int MODE_W     = 2,
  parameter int UC_LO_BIT  = 39,
  parameter int UC_HI_BIT  = 40,
  parameter int SP_TRUNC_W = 40
) (
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic              phys_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sp_en_i,
  output logic              pal_sel_o,
  output logic              phys_sel_o,
  output logic              sp_sel_o,
  output logic              sp_acv_o,
  output logic [VA_W-1:0]   pa_o
);
  localparam logic [VA_W-1:0] PA_MASK =
    {{(VA_W-PA_IMPL_W){1'b0}}, {PA_IMPL_W{1'b1}}};
  localparam logic [VA_W-1:0] SP_EXT =
    {{(VA_W-PA_IMPL_W){1'b0}}, {(PA_IMPL_W-SP_TRUNC_W){1'b1}}, {SP_TRUNC_W{1'b0}}};
  localparam logic [VA_W-1:0] SP_TRUNC =
    {{(VA_W-SP_TRUNC_W){1'b0}}, {SP_TRUNC_W{1'b1}}};
  localparam logic [1:0] SP_SPACE = 2'b10;

  logic [VA_W-1:0] masked_va;
  logic            in_window;

  assign masked_va  = vaddr_i & PA_MASK;
  assign in_window  = sp_en_i && (vaddr_i[VA_IMPL_W-1 -: 2] == SP_SPACE);

  // fixed priority: code marker, physical flag, kernel window
  assign pal_sel_o  = vaddr_i[0];
  assign phys_sel_o = !vaddr_i[0] && phys_i;
  assign sp_sel_o   = !vaddr_i[0] && !phys_i && in_window;
  assign sp_acv_o   = sp_sel_o && (mode_i != '0);

  always_comb begin
    if (pal_sel_o) begin
      pa_o = {masked_va[VA_W-1:2], 2'b00};
    end else if (phys_sel_o) begin
      pa_o = vaddr_i;
    end else if (masked_va[UC_LO_BIT] || masked_va[UC_HI_BIT]) begin
      pa_o = masked_va | SP_EXT;
    end else begin
      pa_o = masked_va & SP_TRUNC;
    end
  end
endmodule

// File: rtl/itx_tlb_path.sv
module itx_tlb_path #(
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int PFN_W      = 32,
  parameter int NMODES     = 4,
  parameter int MODE_W     = 2
) (
  input  logic [PAGE_SHIFT-1:0] pofs_i,
  input  logic [MODE_W-1:0]     mode_i,
  input  logic [PFN_W-1:0]      pfn_i,
  input  logic [NMODES-1:0]     xre_i,
  output logic                  xre_ok_o,
  output logic [VA_W-1:0]       pa_o
);
  localparam int RAW_W = PFN_W + PAGE_SHIFT;

  logic [RAW_W-1:0] raw_pa;
  logic [NMODES-1:0] mode_dec;

  assign raw_pa = {pfn_i, pofs_i[PAGE_SHIFT-1:2], 2'b00};
  assign pa_o   = VA_W'(raw_pa);

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    assign mode_dec[m] = (mode_i == MODE_W'(m));
  end

  assign xre_ok_o = |(mode_dec & xre_i);
endmodule

// File: rtl/itx_fault_regs.sv
module itx_fault_regs #(
  parameter int VA_W  = 64,
  parameter int VPN_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [VA_W-1:0]  ptbase_i,
  output logic [VA_W-1:0]  tag_o,
  output logic [VA_W-1:0]  form_o
);
  logic [VA_W-1:0] tag_q, form_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      form_q <= '0;
    end else if (capture_i) begin
      tag_q  <= vaddr_i;
      form_q <= ptbase_i | (VA_W'(vpn_i) << 3);
    end
  end

  assign tag_o  = tag_q;
  assign form_o = form_q;

  a_r9_tag_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> tag_o == $past(vaddr_i));

  a_r10_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(tag_o) && $stable(form_o));
endmodule

// File: rtl/itx_fetch_xlate.sv
module itx_fetch_xlate
  import itx_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_IMPL_W  = 44,
  parameter int VA_IMPL_W  = 43,
  parameter int PAGE_SHIFT = 13,
  parameter int PFN_W      = 32,
  parameter int ASN_W      = 8,
  parameter int NMODES     = 4,
  parameter int UC_LO_BIT  = 39,
  parameter int UC_HI_BIT  = 40,
  parameter int SP_TRUNC_W = 40
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  input  logic [VA_W-1:0]                 vaddr_i,
  input  logic                            phys_i,
  input  logic                            upd_en_i,
  input  logic [$clog2(NMODES)-1:0]       mode_i,
  input  logic [1:0]                      sp_ctl_i,
  input  logic [ASN_W-1:0]                asn_i,
  input  logic [VA_W-1:0]                 ptbase_i,
  output logic [VA_IMPL_W-PAGE_SHIFT-1:0] tlb_vpn_o,
  output logic [ASN_W-1:0]                tlb_asn_o,
  input  logic                            tlb_hit_i,
  input  logic [PFN_W-1:0]                tlb_pfn_i,
  input  logic [NMODES-1:0]               tlb_xre_i,
  output logic [VA_W-1:0]                 paddr_o,
  output logic [1:0]                      fault_o,
  output logic                            uncached_o,
  output logic [VA_W-1:0]                 fault_tag_o,
  output logic [VA_W-1:0]                 va_form_o
);
  localparam int MODE_W = $clog2(NMODES);
  localparam int VPN_W  = VA_IMPL_W - PAGE_SHIFT;
  localparam logic [VA_W-1:0] PA_MASK =
    {{(VA_W-PA_IMPL_W){1'b0}}, {PA_IMPL_W{1'b1}}};

  logic            pal_sel, phys_sel, sp_sel, sp_acv, xre_ok, capture;
  logic [VA_W-1:0] byp_pa, tlb_pa, res_pa;
  itx_fault_e      res_fault;
  logic            unused_sp;

  assign unused_sp = sp_ctl_i[0];
  assign tlb_vpn_o = vaddr_i[VA_IMPL_W-1:PAGE_SHIFT];
  assign tlb_asn_o = asn_i;

  itx_bypass #(
    .VA_W(VA_W), .PA_IMPL_W(PA_IMPL_W), .VA_IMPL_W(VA_IMPL_W), .MODE_W(MODE_W),
    .UC_LO_BIT(UC_LO_BIT), .UC_HI_BIT(UC_HI_BIT), .SP_TRUNC_W(SP_TRUNC_W)
  ) u_bypass (
    .vaddr_i   (vaddr_i),
    .phys_i    (phys_i),
    .mode_i    (mode_i),
    .sp_en_i   (sp_ctl_i[1]),
    .pal_sel_o (pal_sel),
    .phys_sel_o(phys_sel),
    .sp_sel_o  (sp_sel),
    .sp_acv_o  (sp_acv),
    .pa_o      (byp_pa)
  );

  itx_tlb_path #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .PFN_W(PFN_W), .NMODES(NMODES), .MODE_W(MODE_W)
  ) u_tlb (
    .pofs_i  (vaddr_i[PAGE_SHIFT-1:0]),
    .mode_i  (mode_i),
    .pfn_i   (tlb_pfn_i),
    .xre_i   (tlb_xre_i),
    .xre_ok_o(xre_ok),
    .pa_o    (tlb_pa)
  );

  always_comb begin
    res_fault = FLT_NONE;
    res_pa    = '0;
    if (pal_sel || phys_sel) begin
      res_pa = byp_pa;
    end else if (sp_sel) begin
      if (sp_acv) res_fault = FLT_ACV;
      else        res_pa    = byp_pa;
    end else if (!tlb_hit_i) begin
      res_fault = FLT_MISS;
    end else if (!xre_ok) begin
      res_fault = FLT_ACV;
    end else begin
      res_pa = tlb_pa;
    end
    if (res_fault == FLT_NONE && |(res_pa & ~PA_MASK)) begin
      res_fault = FLT_MCHK;
      res_pa    = '0;
    end
    if (!req_valid_i) begin
      res_fault = FLT_NONE;
      res_pa    = '0;
    end
  end

  assign paddr_o    = res_pa;
  assign fault_o    = res_fault;
  assign uncached_o = (res_fault == FLT_NONE) && (res_pa[UC_LO_BIT] || res_pa[UC_HI_BIT]);
  assign capture    = req_valid_i && upd_en_i &&
                      (res_fault == FLT_ACV || res_fault == FLT_MISS);

  itx_fault_regs #(.VA_W(VA_W), .VPN_W(VPN_W)) u_fregs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .vaddr_i  (vaddr_i),
    .vpn_i    (vaddr_i[VA_IMPL_W-1:PAGE_SHIFT]),
    .ptbase_i (ptbase_i),
    .tag_o    (fault_tag_o),
    .form_o   (va_form_o)
  );

  a_r1_marker_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && vaddr_i[0] |-> fault_o == FLT_NONE && paddr_o[1:0] == 2'b00);

  a_r4_window_user_acv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !vaddr_i[0] && !phys_i && sp_ctl_i[1] &&
    vaddr_i[VA_IMPL_W-1 -: 2] == 2'b10 && mode_i != '0 |-> fault_o == FLT_ACV);

  a_r5_miss_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !vaddr_i[0] && !phys_i && !sp_ctl_i[1] && !tlb_hit_i
    |-> fault_o == FLT_MISS);

  a_r8_uncached_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncached_o |-> fault_o == FLT_NONE && paddr_o[PA_IMPL_W-1:0] != '0);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(fault_tag_o));
endmodule

// File: tb/tb_itx_fetch_xlate.sv
`timescale 1ns/1ps
module tb_itx_fetch_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, phys, upd_en, tlb_hit;
  logic [63:0] vaddr, ptbase;
  logic [1:0]  mode, sp_ctl;
  logic [7:0]  asn;
  logic [31:0] tlb_pfn;
  logic [3:0]  tlb_xre;
  logic [29:0] tlb_vpn;
  logic [7:0]  tlb_asn;
  logic [63:0] paddr, fault_tag, va_form;
  logic [1:0]  fault;
  logic        uncached;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] exp_tag = '0;
  logic [63:0] exp_form = '0;

  always #2.5 clk = ~clk;

  itx_fetch_xlate dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .vaddr_i(vaddr),
    .phys_i(phys), .upd_en_i(upd_en), .mode_i(mode), .sp_ctl_i(sp_ctl),
    .asn_i(asn), .ptbase_i(ptbase), .tlb_vpn_o(tlb_vpn), .tlb_asn_o(tlb_asn),
    .tlb_hit_i(tlb_hit), .tlb_pfn_i(tlb_pfn), .tlb_xre_i(tlb_xre),
    .paddr_o(paddr), .fault_o(fault), .uncached_o(uncached),
    .fault_tag_o(fault_tag), .va_form_o(va_form)
  );

  task automatic chk64(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // behavioural reference: R1 marker, R2 physical, R3/R4 window, R5/R6 table, R7 range, R8 uncached
  task automatic model(output logic [63:0] pa, output int f, output bit uc, output string req);
    f = 0; pa = 0; req = "R6";
    if (vaddr[0]) begin
      pa = vaddr & 64'h0000_0FFF_FFFF_FFFC; req = "R1";
    end else if (phys) begin
      pa = vaddr; req = "R2";
    end else if (sp_ctl[1] && vaddr[42:41] == 2'd2) begin
      if (mode != 0) begin f = 1; req = "R4"; end
      else begin
        req = "R3";
        pa = vaddr % (64'd1 << 44);
        if (pa[39] || pa[40]) pa = pa + (64'hF00_0000_0000 & ~pa);
        else pa = pa % (64'd1 << 40);
      end
    end else if (!tlb_hit) begin
      f = 2; req = "R5";
    end else if (!tlb_xre[mode]) begin
      f = 1; req = "R6";
    end else begin
      pa = tlb_pfn * 64'd8192 + (vaddr % 64'd8192) / 4 * 4;
    end
    if (f == 0 && pa >= (64'd1 << 44)) begin f = 3; pa = 0; req = "R7"; end
    if (!req_valid) begin f = 0; pa = 0; req = "R10"; end
    uc = (f == 0) && (pa[39] || pa[40]);
  endtask

  task automatic step(input logic v, input logic [63:0] va, input logic ph, input logic up,
                      input logic [1:0] md, input logic [1:0] sp, input logic hit,
                      input logic [31:0] pfn, input logic [3:0] xre, input logic [63:0] ptb);
    logic [63:0] epa;
    int ef;
    bit euc;
    string rq;
    @(negedge clk);
    req_valid = v; vaddr = va; phys = ph; upd_en = up; mode = md; sp_ctl = sp;
    tlb_hit = hit; tlb_pfn = pfn; tlb_xre = xre; ptbase = ptb; asn = va[63:56] ^ 8'h5A;
    #1;
    // R9/R10: registers reflect all previous cycles
    chk64("R9", "fault_tag", fault_tag, exp_tag);
    chk64("R9", "va_form", va_form, exp_form);
    model(epa, ef, euc, rq);
    chk64(rq, "paddr", paddr, epa);
    chk64(rq, "fault", 64'(fault), 64'(ef));
    chk64("R8", "uncached", 64'(uncached), 64'(euc));
    chk64("R11", "tlb_vpn", 64'(tlb_vpn), (va >> 13) % (64'd1 << 30));
    chk64("R11", "tlb_asn", 64'(tlb_asn), 64'(asn));
    @(posedge clk);
    if (v && up && (ef == 1 || ef == 2)) begin
      exp_tag  = va;
      exp_form = ptb | (((va >> 13) % (64'd1 << 30)) * 8);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    req_valid = 0; vaddr = 0; phys = 0; upd_en = 0; mode = 0; sp_ctl = 0;
    asn = 0; ptbase = 0; tlb_hit = 0; tlb_pfn = 0; tlb_xre = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk64("R10", "reset tag", fault_tag, 64'd0);
    chk64("R10", "reset form", va_form, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1: marker wins over physical flag and window
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 2'd3, 2'b10, 0, 0, 0, 64'h1000);
    // R2: physical flag wins over window; high bits give R7 machine check
    step(1, 64'h0000_0481_2345_6788, 1, 1, 2'd0, 2'b10, 0, 0, 0, 64'h1000);
    step(1, 64'h0004_0000_0000_1000, 1, 1, 2'd0, 2'b10, 0, 0, 0, 64'h1000);
    // R3: window, extended and truncated
    step(1, 64'hABCD_04AB_CDEF_1230, 0, 1, 2'd0, 2'b10, 0, 0, 0, 64'h2000);
    step(1, 64'h1234_0431_2345_6780, 0, 1, 2'd0, 2'b11, 0, 0, 0, 64'h2000);
    // R4 then R5 back to back with capture
    step(1, 64'h0000_0400_0000_2000, 0, 1, 2'd2, 2'b10, 1, 32'h1, 4'hF, 64'hF000_0000);
    step(1, 64'h0000_0600_0000_4000, 0, 1, 2'd0, 2'b10, 0, 32'h1, 4'hF, 64'hE000_0000);
    // R10: fault with update disabled, then machine check, then idle
    step(1, 64'h0000_0000_0000_8000, 0, 0, 2'd1, 2'b00, 0, 0, 4'hF, 64'hD000_0000);
    step(1, 64'h0000_0000_0000_9004, 0, 1, 2'd1, 2'b00, 1, 32'h8000_0001, 4'hF, 64'hC000_0000);
    step(0, 64'h0000_0000_0000_A000, 0, 1, 2'd1, 2'b00, 0, 0, 4'h0, 64'hB000_0000);
    // R6: hit allowed, hit denied per mode
    step(1, 64'h0000_0000_0000_5FFF & ~64'h1, 0, 1, 2'd3, 2'b00, 1, 32'h0000_0C12, 4'b1000, 64'hA000);
    step(1, 64'h0000_0000_0000_5FFE, 0, 1, 2'd2, 2'b00, 1, 32'h0000_0C12, 4'b1011, 64'hA000);
    // R8: uncached region through the table
    step(1, 64'h0000_0000_0000_0010, 0, 1, 2'd0, 2'b00, 1, 32'h0400_0000, 4'b0001, 64'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] va;
      va = {$urandom, $urandom};
      if ($urandom % 8 != 0) va[0] = 1'b0;
      if ($urandom % 3 == 0) va[42:41] = 2'd2;
      step(($urandom % 8) != 0, va, ($urandom % 6) == 0, ($urandom % 3) != 0,
           2'($urandom), 2'($urandom), ($urandom % 4) != 0, $urandom,
           4'($urandom), {$urandom, $urandom});
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule